// File: doc/BRIEF.md
# Stretched Edge Pulse Detector

This block turns the rising edge of a slow, level-type strobe (for example a pushbutton that has already been synchronized and debounced upstream) into a short pulse. The strobe may stay high or low for any number of cycles. The pulse reacts to the low-to-high transition only.

The pulse starts combinationally, in the same cycle in which the strobe is first seen high. A dedicated hold state then keeps it high for one further full clock cycle, whatever the strobe does in that cycle. Consumers that sample on the clock therefore see the pulse for two consecutive edges.

The state register can be built with binary or one-hot encoding, chosen by a parameter. Both variants behave the same at the ports.

Top module: `edge_stretch_detector`

## Requirements
- R1: The machine has exactly three states: idle-low (encoding 0), hold (encoding 1) and steady-high (encoding 2). An active-high reset forces idle-low, and with strobe low the pulse is low after reset.
- R2: In idle-low with strobe high, the pulse is high in that same cycle, and the next rising clock edge moves the machine to hold.
- R3: In hold, the pulse is high whatever the value of strobe.
- R4: From hold, the next rising edge goes to steady-high if strobe is 1 and to idle-low if strobe is 0.
- R5: In steady-high, the pulse is low. The machine stays there while strobe is 1 and returns to idle-low on the first edge that sees strobe 0.
- R6: In idle-low with strobe low, the machine stays in idle-low with the pulse low.
- R7: A strobe that is high for exactly one cycle still gives the full stretched pulse: two sampled cycles high, followed by a low pulse in idle-low.
- R8: Reset is asynchronous. Asserting it while the machine is in hold drops the pulse (with strobe low) without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| strobe_i | input | 1 | Level strobe, already synchronous to clk |
| pulse_o | output | 1 | Stretched edge pulse |

## Verification
The hardest situation to reach from the ports is the hold state combined with a strobe that has already fallen. Only a strobe that is high for exactly one cycle reaches it, and it shows whether the pulse is held by the state or is merely following the input. The stimulus drives single-cycle strobes, strobes that are high for two cycles and long strobes, back-to-back and interleaved. It also includes a strobe that rises again in the first cycle after hold returns to idle-low. An asynchronous reset is asserted in the middle of a cycle while the machine sits in hold.

// File: rtl/sep_pkg.sv
package sep_pkg;
   localparam int SEP_NUM_STATES = 3;
   localparam int SEP_STATE_W    = $clog2(SEP_NUM_STATES);

   typedef enum logic [SEP_STATE_W-1:0] {
      ST_LOW  = 2'd0,
      ST_HOLD = 2'd1,
      ST_HIGH = 2'd2
   } sep_state_e;

   localparam int SEP_STYLE_BINARY = 0;
   localparam int SEP_STYLE_ONEHOT = 1;
endpackage

// File: rtl/sep_next_logic.sv
module sep_next_logic
   import sep_pkg::*;
(
   input  sep_state_e cur_i,
   input  logic       strobe_i,
   output sep_state_e nxt_o
);
   always_comb begin
      nxt_o = ST_LOW;
      unique case (cur_i)
         ST_LOW:  nxt_o = strobe_i ? ST_HOLD : ST_LOW;
         ST_HOLD: nxt_o = strobe_i ? ST_HIGH : ST_LOW;
         ST_HIGH: nxt_o = strobe_i ? ST_HIGH : ST_LOW;
         default: nxt_o = ST_LOW;
      endcase
   end
endmodule

// File: rtl/sep_state_reg.sv
module sep_state_reg
   import sep_pkg::*;
#(
   parameter int STATE_STYLE = SEP_STYLE_BINARY
) (
   input  logic       clk,
   input  logic       rst,
   input  sep_state_e nxt_i,
   output sep_state_e cur_o
);
   generate
      if (STATE_STYLE == SEP_STYLE_ONEHOT) begin : g_onehot
         logic [SEP_NUM_STATES-1:0] hot_d;
         logic [SEP_NUM_STATES-1:0] hot_q;

         always_comb begin
            hot_d = '0;
            unique case (nxt_i)
               ST_HOLD: hot_d[1] = 1'b1;
               ST_HIGH: hot_d[2] = 1'b1;
               default: hot_d[0] = 1'b1;
            endcase
         end

         always_ff @(posedge clk or posedge rst) begin
            if (rst) hot_q <= SEP_NUM_STATES'(1);
            else     hot_q <= hot_d;
         end

         always_comb begin
            if (hot_q[1])      cur_o = ST_HOLD;
            else if (hot_q[2]) cur_o = ST_HIGH;
            else               cur_o = ST_LOW;
         end
      end else begin : g_binary
         sep_state_e bin_q;

         always_ff @(posedge clk or posedge rst) begin
            if (rst) bin_q <= ST_LOW;
            else     bin_q <= nxt_i;
         end

         assign cur_o = bin_q;
      end
   endgenerate
endmodule

// File: rtl/sep_pulse_logic.sv
module sep_pulse_logic
   import sep_pkg::*;
(
   input  sep_state_e cur_i,
   input  logic       strobe_i,
   output logic       pulse_o
);
   logic edge_term;
   logic hold_term;

   assign edge_term = (cur_i == ST_LOW) && strobe_i;
   assign hold_term = (cur_i == ST_HOLD);
   assign pulse_o   = edge_term | hold_term;
endmodule

// File: rtl/edge_stretch_detector.sv
module edge_stretch_detector
   import sep_pkg::*;
#(
   parameter int STATE_STYLE = SEP_STYLE_BINARY
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   output logic pulse_o
);
   initial begin
      if (!(STATE_STYLE == SEP_STYLE_BINARY || STATE_STYLE == SEP_STYLE_ONEHOT))
         $error("edge_stretch_detector: STATE_STYLE must be 0 or 1");
   end

   sep_state_e state_q;
   sep_state_e state_d;

   sep_next_logic u_next (
      .cur_i    (state_q),
      .strobe_i (strobe_i),
      .nxt_o    (state_d)
   );

   sep_state_reg #(.STATE_STYLE(STATE_STYLE)) u_sreg (
      .clk   (clk),
      .rst   (rst),
      .nxt_i (state_d),
      .cur_o (state_q)
   );

   sep_pulse_logic u_pulse (
      .cur_i    (state_q),
      .strobe_i (strobe_i),
      .pulse_o  (pulse_o)
   );
endmodule

// File: rtl/sep_checker.sv
module sep_checker
   import sep_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       strobe_i,
   input logic       pulse_o,
   input sep_state_e state
);
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (state == ST_LOW || state == ST_HOLD || state == ST_HIGH)); // R1

   AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_LOW && strobe_i) |-> pulse_o); // R2

   AST_EDGE_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
      (state == ST_LOW && strobe_i) |=> (state == ST_HOLD)); // R2

   AST_HOLD_PULSE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HOLD) |-> pulse_o); // R3

   AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HOLD && !strobe_i) |=> (state == ST_LOW)); // R4

   AST_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HIGH) |-> !pulse_o); // R5

   AST_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_LOW && !strobe_i) |-> (!pulse_o ##1 state == ST_LOW)); // R6
endmodule

bind edge_stretch_detector sep_checker chk_i (
   .clk      (clk),
   .rst      (rst),
   .strobe_i (strobe_i),
   .pulse_o  (pulse_o),
   .state    (state_q)
);

// File: tb/edge_stretch_detector_tb_top.sv
module edge_stretch_detector_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic strobe = 1'b0;
   logic pulse;

   int n_vec  = 0;
   int n_fail = 0;
   int m_st   = 0;   // model: 0 idle-low, 1 hold, 2 steady-high
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   edge_stretch_detector dut_i (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (strobe),
      .pulse_o  (pulse)
   );

   function automatic bit model_pulse(int st, bit s);
      return (st == 1) || (st == 0 && s);
   endfunction

   function automatic int model_next(int st, bit s);
      if (!s) return 0;
      return (st == 0) ? 1 : 2;
   endfunction

   task automatic check(string tag, bit exp_v);
      n_vec++;
      if (pulse !== exp_v) begin
         n_fail++;
         $display("FAIL %s: pulse=%0b expected=%0b at %0t", tag, pulse, exp_v, $time);
      end
   endtask

   // drive at negedge, compare mid low phase, advance model for coming edge
   task automatic step(bit s, string tag_over = "");
      string tag;
      @(negedge clk);
      strobe = s;
      #5;
      if (tag_over != "")       tag = tag_over;
      else if (m_st == 1)       tag = "R3 R4";
      else if (m_st == 2)       tag = "R5";
      else if (s)               tag = "R2";
      else                      tag = "R6";
      check(tag, model_pulse(m_st, s));
      m_st = model_next(m_st, s);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      #5 check("R1", 1'b0);
      rst = 1'b0;
      m_st = 0;
      step(0, "R1");
      step(0);
      // R2, R4, R5: long strobe
      step(1);
      step(1);
      repeat (4) step(1);
      step(0);
      step(0);
      // R7: single-cycle strobe
      step(1, "R7");
      step(0, "R7");
      step(0, "R7");
      // two-cycle strobe
      step(1); step(1); step(0);
      // R3: re-rise right after hold falls back to idle-low
      step(1); step(0); step(1); step(0); step(1); step(1); step(0);
      // pseudo-random mixed pattern
      for (int i = 0; i < 300; i++) step(bit'(((i * 7) ^ (i >> 2)) % 3 == 0));
      for (int i = 0; i < 100; i++) step(bit'((i % 5) < 2));
      // R8: asynchronous reset while in hold
      step(0); step(0);
      step(1, "R8");
      @(negedge clk);
      strobe = 1'b0;
      #3 check("R8", 1'b1);
      rst = 1'b1;
      #2 check("R8", 1'b0);
      @(negedge clk);
      #5 check("R8", 1'b0);
      rst = 1'b0;
      m_st = 0;
      step(0, "R8");
      step(1);
      step(0);
      step(0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule